// File: doc/BRIEF.md
# Chain conversion readback sequencer

This block runs one complete measurement pass over a daisy chain of one to eight battery-monitor devices. Each device holds six cell channels and six auxiliary channels. When it is started, the block works out how long the chain's conversion will take, sends two broadcast set-up writes through a word-level SPI transfer handshake, and waits out that time. It then clocks in one 32-bit response per channel. It checks each response's CRC, reports each channel's 12-bit result with its alert class, and adds up the cell results.

The state machine has seven states. `S_IDLE` goes to `S_CALC` on start. `S_CALC` goes to `S_WR_PTR` once the microsecond count is ready. `S_WR_PTR` goes to `S_WR_CTRL` on the transfer acknowledge. `S_WR_CTRL` goes to `S_WAIT` on the acknowledge. `S_WAIT` goes to `S_READ` when the wait expires. `S_READ` stays in `S_READ` on each acknowledged good word, and goes to `S_DONE` on the last word or on a CRC failure. `S_DONE` goes back to `S_IDLE` after one cycle. A transfer is requested with `xfer_req`, and the word is taken on the cycle in which `xfer_ack` is high.

Top module: `cseq_top`

## Requirements
- R1: The pass starts with two writes, in this order.
  - The first sets the read pointer: device 0, register 0x1C, data 0x00, broadcast bit set.
  - The second sets control-high: device 0, register 0x0D, data 0x08 | (avg_sel << 1), broadcast bit set.
  - A write word is laid out as device[31:27], register[26:21], data[20:13] and broadcast[12]. The CRC of bits [31:11] sits in [10:3], and bit 1 is 1.
  - Every read transfer sends 0xF800030A.
- R2: The block waits (ceil(ns/1000) + 5) × CLK_PER_US cycles between the control write and the first read. Here ns = (tA + 695) × 12 × nAVG − tA + dev_cnt_m1 × 250. acq_sel 0..3 selects tA as 465, 1010, 1460 or 1890. avg_sel 0..3 selects nAVG as 1, 2, 4 or 8.
- R3: A pass that has no error makes exactly (dev_cnt_m1 + 1) × 12 read transfers.
- R4: The CRC is the remainder of a value divided by x^8+x^5+x^3+x^2+x+1. For a response, the value is bits [31:10] and the CRC must equal bits [9:2]. On a mismatch the pass ends at once: no further transfers, `done` goes high with err = 1 and sum = 0, and the bad word is not reported.
- R5: The sum adds result field [22:11] of every response whose channel field [26:23] is 5 or less. No other response is added.
- R6: A cell result (channel 0..5) is rising when it is at or above cell_hi. Otherwise it is falling when it is at or below cell_lo.
- R7: An auxiliary result (channel 6..11) is classified in the same way against aux_hi and aux_lo.
- R8: At the end of the pass `done` is high for exactly one cycle. On success err is 0.
- R9: A start that arrives while `busy` is high is ignored. The pass keeps its configuration and no second pass follows.
- R10: After reset `busy`, `done`, `xfer_req` and `res_valid` are low, and `err` and `sum` are 0.
- R11: `res_valid` is high for one cycle after each acknowledged good response. It carries that response's channel, result and rise or fall class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a pass when idle |
| dev_cnt_m1 | input | 3 | Number of devices in the chain minus one |
| acq_sel | input | 2 | Acquisition-time code |
| avg_sel | input | 2 | Averaging code |
| cell_hi | input | 8 | Cell high threshold |
| cell_lo | input | 8 | Cell low threshold |
| aux_hi | input | 8 | Auxiliary high threshold |
| aux_lo | input | 8 | Auxiliary low threshold |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| sum | output | 32 | Sum of the cell results |
| err | output | 2 | 0 = success, 1 = CRC error |
| xfer_req | output | 1 | Requests a 32-bit transfer |
| xfer_wdata | output | 32 | Word to send |
| xfer_ack | input | 1 | Transfer complete, xfer_rdata valid |
| xfer_rdata | input | 32 | Word received |
| res_valid | output | 1 | Per-channel result strobe |
| res_chan | output | 4 | Channel field of the result |
| res_value | output | 12 | 12-bit result |
| res_rise | output | 1 | Result at or above its high threshold |
| res_fall | output | 1 | Result at or below its low threshold and not rising |

## Verification
The bench sweeps all sixteen acquisition and averaging codes on a single device. A wrong table entry or a wrong rounding then shows up as a one-microsecond error in the measured wait. It then runs chain lengths from two to eight devices, which checks the per-device delay term and the read count. Every pass feeds channels whose values sit exactly on each threshold and one step inside it, plus values that lie between the cell and the auxiliary thresholds. These separate "at or above" from "above" and cell thresholds from auxiliary ones. Corrupted CRC bits in the first and in a later device show the abort path, and a start pulsed mid-pass shows that it is ignored.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CALC,
        S_WR_PTR,
        S_WR_CTRL,
        S_WAIT,
        S_READ,
        S_DONE
    } cseq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_CRC  = 2'd1
    } cseq_err_e;

    localparam int CH_W  = 4;
    localparam int VAL_W = 12;

    localparam logic [5:0]  REG_CTRL_HI  = 6'h0D;
    localparam logic [5:0]  REG_RD_PTR   = 6'h1C;
    localparam logic [31:0] READ_TX_WORD = 32'hF800_030A;
    localparam logic [8:0]  CRC_POLY     = 9'h12F;

    // Remainder of a 24-bit polynomial divided by the 8th-order generator.
    function automatic logic [7:0] crc_rem(input logic [23:0] v);
        logic [23:0] t;
        t = v;
        for (int i = 23; i >= 8; i--) begin
            if (t[i]) t = t ^ (24'(CRC_POLY) << (i - 8));
        end
        return t[7:0];
    endfunction

    function automatic logic [31:0] build_write(input logic [4:0] dev,
                                                input logic [5:0] regsel,
                                                input logic [7:0] data,
                                                input logic       bcast);
        logic [31:0] w;
        w       = {dev, regsel, data, bcast, 12'h000};
        w[10:3] = crc_rem({3'b000, w[31:11]});
        w[1]    = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/cseq_delay.sv
module cseq_delay #(
    parameter int CLK_PER_US = 200,
    parameter int DEV_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             calc_go,
    input  logic [1:0]       acq_sel,
    input  logic [1:0]       avg_sel,
    input  logic [DEV_W-1:0] dev_cnt_m1,
    output logic             calc_ready,
    input  logic             wait_go,
    output logic             wait_done
);
    localparam int NS_W  = 20;
    localparam int US_W  = 10;
    localparam int PRE_W = $clog2(CLK_PER_US + 1);
    localparam int TAIL_US = 5;

    logic [NS_W-1:0]  tacq_ns, conv_ns, ns_total;
    logic [NS_W-1:0]  rem_q;
    logic [US_W-1:0]  us_q;
    logic [US_W-1:0]  left_q;
    logic [PRE_W-1:0] pre_q;

    always_comb begin
        unique case (acq_sel)
            2'd0: tacq_ns = NS_W'(465);
            2'd1: tacq_ns = NS_W'(1010);
            2'd2: tacq_ns = NS_W'(1460);
            2'd3: tacq_ns = NS_W'(1890);
        endcase
        conv_ns  = ((tacq_ns + NS_W'(695)) * NS_W'(12)) << avg_sel;
        ns_total = conv_ns - tacq_ns + NS_W'(dev_cnt_m1) * NS_W'(250);
    end

    // Ceiling division by 1000: one subtraction per cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            us_q  <= '0;
        end else if (calc_go) begin
            rem_q <= ns_total;
            us_q  <= '0;
        end else if (rem_q != '0) begin
            rem_q <= (rem_q > NS_W'(1000)) ? rem_q - NS_W'(1000) : '0;
            us_q  <= us_q + 1'b1;
        end
    end

    assign calc_ready = (rem_q == '0);

    // Microsecond down-counter with a clock prescaler.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
            pre_q  <= '0;
        end else if (wait_go) begin
            left_q <= us_q + US_W'(TAIL_US);
            pre_q  <= PRE_W'(CLK_PER_US - 1);
        end else if (left_q != '0) begin
            if (pre_q == '0) begin
                pre_q  <= PRE_W'(CLK_PER_US - 1);
                left_q <= left_q - 1'b1;
            end else begin
                pre_q <= pre_q - 1'b1;
            end
        end
    end

    assign wait_done = (left_q == US_W'(1)) && (pre_q == '0);

    AST_CALC_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!calc_go && rem_q != '0) |=> (rem_q < $past(rem_q))); // R2
    AST_WAIT_PRESCALE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_go && left_q != '0 && pre_q != '0) |=> (left_q == $past(left_q))); // R2

endmodule

// File: rtl/cseq_frame_chk.sv
module cseq_frame_chk
    import cseq_pkg::*;
(
    input  logic [31:0]      rdata,
    output logic             crc_ok,
    output logic [CH_W-1:0]  chan,
    output logic [VAL_W-1:0] value
);
    logic unused_low;

    assign crc_ok     = (crc_rem({2'b00, rdata[31:10]}) == rdata[9:2]);
    assign chan       = rdata[26:23];
    assign value      = rdata[22:11];
    assign unused_low = ^rdata[1:0];

endmodule

// File: rtl/cseq_classify.sv
module cseq_classify
    import cseq_pkg::*;
#(
    parameter int CELL_CH = 6,
    parameter int THR_W   = 8
) (
    input  logic [CH_W-1:0]  chan,
    input  logic [VAL_W-1:0] value,
    input  logic [THR_W-1:0] cell_hi,
    input  logic [THR_W-1:0] cell_lo,
    input  logic [THR_W-1:0] aux_hi,
    input  logic [THR_W-1:0] aux_lo,
    output logic             is_cell,
    output logic             rise,
    output logic             fall
);
    logic [THR_W-1:0] hi_sel, lo_sel;

    always_comb begin
        is_cell = (32'(chan) < CELL_CH);
        hi_sel  = is_cell ? cell_hi : aux_hi;
        lo_sel  = is_cell ? cell_lo : aux_lo;
        rise    = (value >= VAL_W'(hi_sel));
        fall    = !rise && (value <= VAL_W'(lo_sel));
    end

endmodule

// File: rtl/cseq_top.sv
module cseq_top
    import cseq_pkg::*;
#(
    parameter int CLK_PER_US = 200,
    parameter int MAX_DEV    = 8,
    parameter int CH_PER_DEV = 12,
    parameter int CELL_CH    = 6,
    parameter int THR_W      = 8,
    parameter int SUM_W      = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [$clog2(MAX_DEV)-1:0] dev_cnt_m1,
    input  logic [1:0]                 acq_sel,
    input  logic [1:0]                 avg_sel,
    input  logic [THR_W-1:0]           cell_hi,
    input  logic [THR_W-1:0]           cell_lo,
    input  logic [THR_W-1:0]           aux_hi,
    input  logic [THR_W-1:0]           aux_lo,
    output logic                       busy,
    output logic                       done,
    output logic [SUM_W-1:0]           sum,
    output logic [1:0]                 err,
    output logic                       xfer_req,
    output logic [31:0]                xfer_wdata,
    input  logic                       xfer_ack,
    input  logic [31:0]                xfer_rdata,
    output logic                       res_valid,
    output logic [3:0]                 res_chan,
    output logic [11:0]                res_value,
    output logic                       res_rise,
    output logic                       res_fall
);
    localparam int DEV_W = $clog2(MAX_DEV);
    localparam int IDX_W = $clog2(MAX_DEV * CH_PER_DEV + 1);

    cseq_state_e state_q, state_d;

    logic [DEV_W-1:0] dev_q;
    logic [1:0]       avg_q;
    logic [THR_W-1:0] cell_hi_q, cell_lo_q, aux_hi_q, aux_lo_q;
    logic [IDX_W-1:0] idx_q, last_idx;
    logic [SUM_W-1:0] acc_q;
    cseq_err_e        err_q;

    logic             res_valid_q, res_rise_q, res_fall_q;
    logic [CH_W-1:0]  res_chan_q;
    logic [VAL_W-1:0] res_value_q;

    logic             calc_go, calc_ready, wait_go, wait_done, word_ack;
    logic             rd_crc_ok;
    logic [CH_W-1:0]  rd_chan;
    logic [VAL_W-1:0] rd_value;
    logic             cls_cell, cls_rise, cls_fall;
    logic [7:0]       ctrl_data;

    assign calc_go   = (state_q == S_IDLE) && start;
    assign wait_go   = (state_q == S_WR_CTRL) && xfer_ack;
    assign word_ack  = (state_q == S_READ) && xfer_ack;
    assign last_idx  = IDX_W'((32'(dev_q) + 1) * CH_PER_DEV - 1);
    assign ctrl_data = {2'b00, 2'b00, 1'b1, avg_q, 1'b0};

    cseq_delay #(
        .CLK_PER_US (CLK_PER_US),
        .DEV_W      (DEV_W)
    ) u_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .calc_go    (calc_go),
        .acq_sel    (acq_sel),
        .avg_sel    (avg_sel),
        .dev_cnt_m1 (dev_cnt_m1),
        .calc_ready (calc_ready),
        .wait_go    (wait_go),
        .wait_done  (wait_done)
    );

    cseq_frame_chk u_frame_chk (
        .rdata  (xfer_rdata),
        .crc_ok (rd_crc_ok),
        .chan   (rd_chan),
        .value  (rd_value)
    );

    cseq_classify #(
        .CELL_CH (CELL_CH),
        .THR_W   (THR_W)
    ) u_classify (
        .chan    (rd_chan),
        .value   (rd_value),
        .cell_hi (cell_hi_q),
        .cell_lo (cell_lo_q),
        .aux_hi  (aux_hi_q),
        .aux_lo  (aux_lo_q),
        .is_cell (cls_cell),
        .rise    (cls_rise),
        .fall    (cls_fall)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start)      state_d = S_CALC;
            S_CALC:    if (calc_ready) state_d = S_WR_PTR;
            S_WR_PTR:  if (xfer_ack)   state_d = S_WR_CTRL;
            S_WR_CTRL: if (xfer_ack)   state_d = S_WAIT;
            S_WAIT:    if (wait_done)  state_d = S_READ;
            S_READ: begin
                if (xfer_ack && (!rd_crc_ok || idx_q == last_idx)) state_d = S_DONE;
            end
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_q       <= '0;
            avg_q       <= '0;
            cell_hi_q   <= '1;
            cell_lo_q   <= '0;
            aux_hi_q    <= '1;
            aux_lo_q    <= '0;
            idx_q       <= '0;
            acc_q       <= '0;
            err_q       <= ERR_NONE;
            res_valid_q <= 1'b0;
            res_rise_q  <= 1'b0;
            res_fall_q  <= 1'b0;
            res_chan_q  <= '0;
            res_value_q <= '0;
        end else begin
            res_valid_q <= 1'b0;
            res_rise_q  <= 1'b0;
            res_fall_q  <= 1'b0;
            if (calc_go) begin
                dev_q     <= dev_cnt_m1;
                avg_q     <= avg_sel;
                cell_hi_q <= cell_hi;
                cell_lo_q <= cell_lo;
                aux_hi_q  <= aux_hi;
                aux_lo_q  <= aux_lo;
                idx_q     <= '0;
                acc_q     <= '0;
                err_q     <= ERR_NONE;
            end
            if (word_ack) begin
                if (!rd_crc_ok) begin
                    err_q <= ERR_CRC;
                end else begin
                    res_valid_q <= 1'b1;
                    res_chan_q  <= rd_chan;
                    res_value_q <= rd_value;
                    res_rise_q  <= cls_rise;
                    res_fall_q  <= cls_fall;
                    idx_q       <= idx_q + 1'b1;
                    if (cls_cell) acc_q <= acc_q + SUM_W'(rd_value);
                end
            end
        end
    end

    always_comb begin
        unique case (state_q)
            S_WR_PTR:  xfer_wdata = build_write(5'd0, REG_RD_PTR, 8'h00, 1'b1);
            S_WR_CTRL: xfer_wdata = build_write(5'd0, REG_CTRL_HI, ctrl_data, 1'b1);
            default:   xfer_wdata = READ_TX_WORD;
        endcase
    end

    assign xfer_req  = (state_q == S_WR_PTR) || (state_q == S_WR_CTRL) || (state_q == S_READ);
    assign busy      = (state_q != S_IDLE);
    assign done      = (state_q == S_DONE);
    assign err       = err_q;
    assign sum       = (err_q == ERR_NONE) ? acc_q : '0;
    assign res_valid = res_valid_q;
    assign res_chan  = res_chan_q;
    assign res_value = res_value_q;
    assign res_rise  = res_rise_q;
    assign res_fall  = res_fall_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(dev_q) && $stable(avg_q))); // R9
    AST_CRC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ack && !rd_crc_ok) |=> (done && err == 2'd1 && !xfer_req)); // R4
    AST_AUX_NOT_SUMMED: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ack && rd_crc_ok && !cls_cell) |=> (acc_q == $past(acc_q))); // R5
    AST_RISE_FALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_rise && res_fall)); // R6
    AST_WORD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_READ) |-> (idx_q <= last_idx)); // R3

endmodule

// File: tb/cseq_top_bench.sv
`timescale 1ns/1ps
module cseq_top_bench;
    localparam int CPU = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  dev_cnt_m1 = '0;
    logic [1:0]  acq_sel = '0, avg_sel = '0;
    logic [7:0]  cell_hi = 8'h90, cell_lo = 8'h30, aux_hi = 8'hC8, aux_lo = 8'h18;
    logic        busy, done, xfer_req, xfer_ack, res_valid, res_rise, res_fall;
    logic [31:0] sum, xfer_wdata, xfer_rdata;
    logic [1:0]  err;
    logic [3:0]  res_chan;
    logic [11:0] res_value;

    int compared = 0, mismatched = 0;
    int xn = 0, cyc = 0, bad_idx = -1, seed = 0, mon_cnt = 0;
    logic [31:0] wlog [0:127];
    int          tlog [0:127];

    always #2.5 clk = ~clk;

    cseq_top #(.CLK_PER_US(CPU)) u_cseq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_cnt_m1(dev_cnt_m1),
        .acq_sel(acq_sel), .avg_sel(avg_sel), .cell_hi(cell_hi), .cell_lo(cell_lo),
        .aux_hi(aux_hi), .aux_lo(aux_lo), .busy(busy), .done(done), .sum(sum),
        .err(err), .xfer_req(xfer_req), .xfer_wdata(xfer_wdata), .xfer_ack(xfer_ack),
        .xfer_rdata(xfer_rdata), .res_valid(res_valid), .res_chan(res_chan),
        .res_value(res_value), .res_rise(res_rise), .res_fall(res_fall)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] tab(input logic [7:0] b);
        logic [7:0] c;
        c = b;
        for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'h2F) : (c << 1);
        return c;
    endfunction

    function automatic logic [7:0] bcrc(input logic [23:0] v);
        logic [7:0] c;
        c = tab(v[23:16]);
        c = tab(c ^ v[15:8]);
        return c ^ v[7:0];
    endfunction

    function automatic logic [31:0] exp_write(input logic [5:0] r, input logic [7:0] d);
        logic [31:0] w;
        w = (32'(r) << 21) | (32'(d) << 13) | 32'h1000;
        w = w | (32'(bcrc(24'(w >> 11))) << 3) | 32'h2;
        return w;
    endfunction

    function automatic int vgen(input int i);
        case (i % 12)
            0: return int'(cell_hi);
            1: return int'(cell_lo);
            2: return int'(cell_hi) - 1;
            3: return int'(cell_lo) + 1;
            4: return 32'h20;
            6: return int'(aux_hi);
            7: return int'(aux_lo);
            8: return int'(aux_hi) - 1;
            9: return 32'hA0;
            11: return 32'hFFF;
            default: return (i * 53 + seed * 29) % 300;
        endcase
    endfunction

    function automatic logic [31:0] mk_word(input int i);
        logic [31:0] w;
        w = (32'(i / 12) << 27) | (32'(i % 12) << 23) | (32'(vgen(i)) << 11);
        w = w | (32'(bcrc(24'(w >> 10))) << 2);
        return w;
    endfunction

    function automatic int exp_wait(input int dm1, input int acq, input int avg);
        int ta, ns;
        case (acq)
            0: ta = 465;
            1: ta = 1010;
            2: ta = 1460;
            default: ta = 1890;
        endcase
        ns = (ta + 695) * 12 * (1 << avg) - ta + dm1 * 250;
        return ((ns + 999) / 1000 + 5) * CPU;
    endfunction

    // Transfer responder
    initial begin
        xfer_ack = 1'b0;
        xfer_rdata = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (xfer_ack) xfer_ack = 1'b0;
            else if (xfer_req) begin
                if (xn < 128) begin
                    wlog[xn] = xfer_wdata;
                    tlog[xn] = cyc;
                end
                if (xn >= 2) begin
                    xfer_rdata = mk_word(xn - 2);
                    if (xn - 2 == bad_idx) xfer_rdata = xfer_rdata ^ 32'h4;
                end
                xn++;
                xfer_ack = 1'b1;
            end
        end
    end

    // Per-word result monitor
    initial begin
        forever begin
            @(negedge clk);
            if (res_valid) begin
                int v, hi, lo;
                bit er, ef, aux;
                v   = vgen(mon_cnt);
                aux = (mon_cnt % 12) > 5;
                hi  = aux ? int'(aux_hi) : int'(cell_hi);
                lo  = aux ? int'(aux_lo) : int'(cell_lo);
                er  = v >= hi;
                ef  = !er && v <= lo;
                chk(res_chan == 4'(mon_cnt % 12) && res_value == 12'(v),
                    "R11 word", longint'(res_value), longint'(v));
                chk(res_rise == er && res_fall == ef, aux ? "R7 aux class" : "R6 cell class",
                    longint'({res_rise, res_fall}), longint'({er, ef}));
                mon_cnt++;
            end
        end
    end

    task automatic run_pass(input int dm1, input int acq, input int avg, input int bad);
        int nwords, esum, rd_bad, nrep;
        @(negedge clk);
        dev_cnt_m1 = 3'(dm1);
        acq_sel = 2'(acq);
        avg_sel = 2'(avg);
        bad_idx = bad;
        seed++;
        xn = 0;
        mon_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        do @(negedge clk); while (!done);
        nwords = (bad >= 0) ? bad + 1 : (dm1 + 1) * 12;
        nrep   = (bad >= 0) ? bad : nwords;
        esum = 0;
        for (int i = 0; i < nrep; i++) if (i % 12 <= 5) esum += vgen(i);
        if (bad >= 0) begin
            chk(err == 2'd1, "R4 err code", err, 1);
            chk(sum == 0, "R4 sum on abort", sum, 0);
        end else begin
            chk(err == 2'd0, "R8 err code", err, 0);
            chk(sum == 32'(esum), "R5 cell sum", sum, esum);
        end
        chk(xn == 2 + nwords, bad >= 0 ? "R4 transfers" : "R3 transfers", xn, 2 + nwords);
        chk(wlog[0] == exp_write(6'h1C, 8'h00), "R1 pointer write", wlog[0], exp_write(6'h1C, 8'h00));
        chk(wlog[1] == exp_write(6'h0D, 8'h08 | 8'(avg << 1)), "R1 control write",
            wlog[1], exp_write(6'h0D, 8'h08 | 8'(avg << 1)));
        rd_bad = 0;
        for (int i = 2; i < xn && i < 128; i++) if (wlog[i] != 32'hF800030A) rd_bad++;
        chk(rd_bad == 0, "R1 read tx word", rd_bad, 0);
        chk(tlog[2] - tlog[1] == exp_wait(dm1, acq, avg) + 1, "R2 wait cycles",
            tlog[2] - tlog[1] - 1, exp_wait(dm1, acq, avg));
        @(negedge clk);
        chk(!done, "R8 done width", done, 0);
        chk(mon_cnt == nrep, "R11 result count", mon_cnt, nrep);
    endtask

    initial begin
        #(5.0 * 200000);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int n_after;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !xfer_req && !res_valid && err == 0 && sum == 0,
            "R10 reset state", {busy, done, xfer_req, res_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !xfer_req, "R10 idle after reset", {busy, xfer_req}, 0);

        for (int a = 0; a < 4; a++)
            for (int g = 0; g < 4; g++)
                run_pass(0, a, g, -1);
        for (int d = 1; d < 8; d++) run_pass(d, d % 4, (d + 1) % 4, -1);
        run_pass(1, 0, 0, 5);
        run_pass(2, 3, 1, 17);
        run_pass(0, 1, 0, 0);

        // R9: start pulsed mid-pass with a different configuration
        @(negedge clk);
        dev_cnt_m1 = 3'd1; acq_sel = 2'd0; avg_sel = 2'd0; bad_idx = -1;
        xn = 0; mon_cnt = 0; seed++;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (xn < 6) @(negedge clk);
        dev_cnt_m1 = 3'd7; avg_sel = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        do @(negedge clk); while (!done);
        chk(xn == 26, "R9 transfers kept", xn, 26);
        chk(wlog[1] == exp_write(6'h0D, 8'h08), "R9 control kept", wlog[1], exp_write(6'h0D, 8'h08));
        n_after = xn;
        repeat (60) @(negedge clk);
        chk(xn == n_after && !busy, "R9 no second pass", xn, n_after);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule